// File: doc/BRIEF.md
# Framed Serial DAC Command Receiver

This block is the digital front end that sits in front of a 10-bit serial DAC. Four asynchronous pins (an active-low chip select, a frame-sync, a serial clock and serial data) are brought into a fast system clock domain. The block turns them into 16-bit command words. Each accepted word loads a 10-bit code, a speed-mode flag and a power-down flag into output registers. A single-cycle strobe marks each load. A status output shows when the output amplifiers are switched off.

A transfer begins when frame-sync falls while chip select is low. Data bits are taken on serial-clock falling edges, most significant first. After sixteen bits, the next serial-clock rising edge loads the word. If frame-sync rises before that edge, the bits received so far are loaded at once. They are moved up to the top of the word and the missing low bits read as zero. If chip select rises part-way through a transfer, the transfer is dropped and nothing is loaded. The system clock must run at least four times faster than the serial clock.

Top module: `sdac_frame_rx`

## Requirements
- R1: While reset is high, and on the first cycle after it, dac_code, fast_mode, pwr_down, amps_off and update_strobe are all zero.
- R2: A frame starts on a frame-sync falling edge seen while chip select is low. Bits are then shifted in on serial-clock falling edges, first bit received is word bit 15.
- R3: In a frame of sixteen bits, nothing is loaded between the sixteenth serial-clock falling edge and the next serial-clock rising edge. That rising edge loads the word.
- R4: A frame-sync rising edge before that load ends the frame early. The word is loaded with the received bits in the top positions and zeros below. With sixteen bits already in, the full word is loaded. With no bits received, nothing is loaded.
- R5: While chip select is high, activity on frame-sync, serial clock and data loads nothing and leaves the outputs unchanged.
- R6: A chip-select rising edge during a frame drops the frame without any load. A later frame-sync rise does not revive it.
- R7: Field map of the 16-bit word: bit 14 drives fast_mode (1 = fast), bit 13 drives pwr_down (1 = powered down), and bits 11 to 2 drive dac_code (bit 11 is the code MSB). Bits 15, 12, 1 and 0 have no effect.
- R8: update_strobe is high for exactly one system-clock cycle per load. dac_code, fast_mode, pwr_down and amps_off change only in a cycle where update_strobe is high.
- R9: amps_off equals pwr_down after every load.
- R10: update_strobe goes high on the third system-clock rising edge after the committing pin edge, counting from a pin change made before the first of those edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Asynchronous chip select, active low |
| fsync | input | 1 | Asynchronous frame-sync |
| sclk | input | 1 | Asynchronous serial clock |
| sdin | input | 1 | Asynchronous serial data |
| dac_code | output | 10 | Latched DAC code |
| fast_mode | output | 1 | Speed flag, 1 = fast settling |
| pwr_down | output | 1 | Power-down flag |
| amps_off | output | 1 | Status: output amplifiers disabled |
| update_strobe | output | 1 | One-cycle pulse on each load |

## Verification
A bit counter that is off by one appears at the ports in one of two ways. A full frame loads with its fields shifted by one place, or a short frame loads at the wrong alignment. Either is visible at the strobe that follows, about three system cycles after the committing edge. A sequencer stuck outside idle after chip select rises shows up in the next frame. That frame either loads when it should not or stays silent. A latch that moves outside its strobe is caught on the very cycle it moves, because the outputs are compared against their previous values on every cycle.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int WORD_BITS   = 16;
  localparam int CODE_BITS   = 10;
  localparam int CODE_LOW    = 2;
  localparam int SPEED_POS   = 14;
  localparam int PDOWN_POS   = 13;
  localparam int SYNC_DEPTH  = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_FULL  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  // STAGES must be at least 2
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= {STAGES{RST_VAL}};
    else     pipe <= {pipe[STAGES-2:0], d_async};
  end

  assign q_sync = pipe[STAGES-1];
endmodule

// File: rtl/sdac_edge.sv
module sdac_edge #(
  parameter int WIDTH = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= RST_VAL;
    else     prev <= lvl;
  end

  for (genvar g = 0; g < WIDTH; g++) begin : g_lane
    assign rise[g] =  lvl[g] & ~prev[g];
    assign fall[g] = ~lvl[g] &  prev[g];
  end
endmodule

// File: rtl/sdac_frame_shift.sv
module sdac_frame_shift
  import sdac_pkg::*;
#(
  parameter int FRAME_W = WORD_BITS,
  localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_n_s,
  input  logic               din_s,
  input  logic               fs_fall,
  input  logic               fs_rise,
  input  logic               sclk_fall,
  input  logic               sclk_rise,
  output logic               commit,
  output logic [FRAME_W-1:0] commit_word
);
  rx_state_e          state;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] sreg;
  logic [CNT_W-1:0]   pad;

  assign pad = CNT_W'(FRAME_W) - cnt;

  always_comb begin
    commit      = 1'b0;
    commit_word = sreg;
    if (!cs_n_s) begin
      unique case (state)
        ST_SHIFT: if (fs_rise && cnt != '0) begin
          commit      = 1'b1;
          commit_word = sreg << pad;
        end
        ST_FULL: if (sclk_rise || fs_rise) commit = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      sreg  <= '0;
    end else if (cs_n_s) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (fs_fall) begin
          state <= ST_SHIFT;
          cnt   <= '0;
          sreg  <= '0;
        end
        ST_SHIFT: begin
          if (fs_rise) begin
            state <= ST_IDLE;
          end else if (sclk_fall) begin
            sreg <= {sreg[FRAME_W-2:0], din_s};
            cnt  <= cnt + CNT_W'(1);
            if (cnt == CNT_W'(FRAME_W - 1)) state <= ST_FULL;
          end
        end
        ST_FULL: if (sclk_rise || fs_rise) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: the wait-for-rise state is only reached with a full word shifted in
  a_r3_full_count: assert property (@(posedge clk) disable iff (rst)
    state == ST_FULL |-> cnt == CNT_W'(FRAME_W));
  // R2: the bit counter never passes the word length
  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(FRAME_W));
  // R6: chip select high always returns the sequencer to idle
  a_r6_cs_idle: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> state == ST_IDLE);
  // R5: no load is raised while chip select is high
  a_r5_no_commit_cs_high: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |-> !commit);
endmodule

// File: rtl/sdac_out_latch.sv
module sdac_out_latch
  import sdac_pkg::*;
#(
  parameter int FRAME_W  = WORD_BITS,
  parameter int CODE_W   = CODE_BITS,
  parameter int CODE_LSB = CODE_LOW,
  parameter int FAST_BIT = SPEED_POS,
  parameter int PD_BIT   = PDOWN_POS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               commit,
  input  logic [FRAME_W-1:0] word,
  output logic [CODE_W-1:0]  dac_code,
  output logic               fast_mode,
  output logic               pwr_down,
  output logic               amps_off,
  output logic               update_strobe
);
  logic [CODE_W-1:0] code_field;
  logic              unused_word_bits;

  assign code_field       = word[CODE_LSB +: CODE_W];
  assign unused_word_bits = ^word;

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_code      <= '0;
      fast_mode     <= 1'b0;
      pwr_down      <= 1'b0;
      amps_off      <= 1'b0;
      update_strobe <= 1'b0;
    end else begin
      update_strobe <= commit;
      if (commit) begin
        dac_code  <= code_field;
        fast_mode <= word[FAST_BIT];
        pwr_down  <= word[PD_BIT];
        amps_off  <= word[PD_BIT];
      end
    end
  end

  // R1: reset leaves every output at zero
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (dac_code == '0 && !fast_mode && !pwr_down && !amps_off && !update_strobe));
  // R8: the strobe never lasts two cycles
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    update_strobe |=> !update_strobe);
  // R8: outputs move only together with the strobe
  a_r8_hold_between: assert property (@(posedge clk) disable iff (rst)
    !update_strobe |-> ($stable(dac_code) && $stable(fast_mode) && $stable(pwr_down) && $stable(amps_off)));
  // R9: amplifier status tracks the power-down flag
  a_r9_amp_status: assert property (@(posedge clk) disable iff (rst)
    amps_off == pwr_down);
endmodule

// File: rtl/sdac_frame_rx.sv
module sdac_frame_rx
  import sdac_pkg::*;
#(
  parameter int FRAME_W     = WORD_BITS,
  parameter int CODE_W      = CODE_BITS,
  parameter int CODE_LSB    = CODE_LOW,
  parameter int FAST_BIT    = SPEED_POS,
  parameter int PD_BIT      = PDOWN_POS,
  parameter int SYNC_STAGES = SYNC_DEPTH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              fsync,
  input  logic              sclk,
  input  logic              sdin,
  output logic [CODE_W-1:0] dac_code,
  output logic              fast_mode,
  output logic              pwr_down,
  output logic              amps_off,
  output logic              update_strobe
);
  localparam int PIN_W = 4;
  // lane order: {cs_n, fsync, sclk, sdin}; idle levels cs_n=1, fsync=1
  localparam logic [PIN_W-1:0] PIN_IDLE = 4'b1100;

  logic [PIN_W-1:0]   pins_s;
  logic [1:0]         ed_rise, ed_fall;
  logic               commit;
  logic [FRAME_W-1:0] commit_word;

  sdac_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst(rst),
    .d_async({cs_n, fsync, sclk, sdin}),
    .q_sync(pins_s)
  );

  // edge lanes: [1] = frame-sync, [0] = serial clock
  sdac_edge #(.WIDTH(2), .RST_VAL(2'b10)) u_edge (
    .clk(clk), .rst(rst),
    .lvl(pins_s[2:1]),
    .rise(ed_rise),
    .fall(ed_fall)
  );

  sdac_frame_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst(rst),
    .cs_n_s(pins_s[3]),
    .din_s(pins_s[0]),
    .fs_fall(ed_fall[1]),
    .fs_rise(ed_rise[1]),
    .sclk_fall(ed_fall[0]),
    .sclk_rise(ed_rise[0]),
    .commit(commit),
    .commit_word(commit_word)
  );

  sdac_out_latch #(
    .FRAME_W(FRAME_W), .CODE_W(CODE_W), .CODE_LSB(CODE_LSB),
    .FAST_BIT(FAST_BIT), .PD_BIT(PD_BIT)
  ) u_latch (
    .clk(clk), .rst(rst),
    .commit(commit),
    .word(commit_word),
    .dac_code(dac_code),
    .fast_mode(fast_mode),
    .pwr_down(pwr_down),
    .amps_off(amps_off),
    .update_strobe(update_strobe)
  );
endmodule

// File: tb/sim_sdac_frame_rx.sv
module sim_sdac_frame_rx;
  localparam int H = 4;

  logic clk = 1'b0;
  logic rst, cs_n, fsync, sclk, sdin;
  logic [9:0] dac_code;
  logic fast_mode, pwr_down, amps_off, update_strobe;

  int total = 0, fails = 0;
  int strobe_cnt = 0, wide_cnt = 0, glitch_cnt = 0;
  logic prev_s = 1'b0;
  logic [12:0] last_out = '0;
  logic [9:0] m_code = '0;
  logic m_fast = 1'b0, m_pd = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sdac_frame_rx u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .fsync(fsync), .sclk(sclk), .sdin(sdin),
    .dac_code(dac_code), .fast_mode(fast_mode), .pwr_down(pwr_down),
    .amps_off(amps_off), .update_strobe(update_strobe)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (update_strobe) begin
        strobe_cnt++;
        if (prev_s) wide_cnt++;
      end else if ({dac_code, fast_mode, pwr_down, amps_off} != last_out) begin
        glitch_cnt++;
      end
    end
    prev_s   <= update_strobe;
    last_out <= {dac_code, fast_mode, pwr_down, amps_off};
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] align_bits(input logic [15:0] w, input int n);
    logic [31:0] m;
    m = ~(32'h0000FFFF >> n);
    return w & m[15:0];
  endfunction

  // mode 0: full frame, load on SCLK rise; 1: FS ends frame; 2: CS abort; 3: CS held high
  task automatic run_frame(input logic [15:0] w, input int nbits, input int mode);
    int start;
    int lat;
    logic [15:0] a;
    bit expect_load;
    start = strobe_cnt;
    cs_n = (mode == 3);
    wait_cyc(H);
    fsync = 1'b0;
    wait_cyc(H);
    for (int i = 0; i < nbits; i++) begin
      sdin = w[15-i];
      sclk = 1'b1;
      wait_cyc(H);
      sclk = 1'b0;
      wait_cyc(H);
    end
    if (mode == 0) begin
      wait_cyc(H);
      check(strobe_cnt == start, "R3 early load", strobe_cnt - start, 0);
      sclk = 1'b1;
      lat = 0;
      for (int i = 1; i <= H + 2; i++) begin
        @(negedge clk); #1;
        if (lat == 0 && strobe_cnt != start) lat = i;
      end
      check(lat == 3, "R10 latency", lat, 3);
      fsync = 1'b1;
      wait_cyc(H);
      sclk = 1'b0;
      wait_cyc(H);
      cs_n = 1'b1;
    end else if (mode == 1) begin
      fsync = 1'b1;
      wait_cyc(H);
      cs_n = 1'b1;
    end else if (mode == 2) begin
      cs_n = 1'b1;
      wait_cyc(H);
      fsync = 1'b1;
    end else begin
      fsync = 1'b1;
    end
    wait_cyc(2 * H);
    #1;
    expect_load = (mode == 0) || (mode == 1 && nbits > 0);
    if (expect_load) begin
      a = align_bits(w, nbits);
      m_code = a[11:2];
      m_fast = a[14];
      m_pd   = a[13];
    end
    if (mode == 0) begin
      check(strobe_cnt - start == 1, "R2 one load", strobe_cnt - start, 1);
      check(dac_code == m_code, "R7 code", dac_code, m_code);
    end else if (mode == 1) begin
      check(strobe_cnt - start == (nbits > 0 ? 1 : 0), "R4 load count", strobe_cnt - start, nbits > 0 ? 1 : 0);
      check(dac_code == m_code, "R4 aligned code", dac_code, m_code);
    end else if (mode == 2) begin
      check(strobe_cnt == start, "R6 abort", strobe_cnt - start, 0);
      check(dac_code == m_code, "R6 code kept", dac_code, m_code);
    end else begin
      check(strobe_cnt == start, "R5 cs high", strobe_cnt - start, 0);
      check(dac_code == m_code, "R5 code kept", dac_code, m_code);
    end
    check(fast_mode == m_fast, "R7 fast_mode", fast_mode, m_fast);
    check(pwr_down == m_pd, "R7 pwr_down", pwr_down, m_pd);
    check(amps_off == m_pd, "R9 amps_off", amps_off, m_pd);
    wait_cyc(H);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'd5606);
    rst = 1'b1; cs_n = 1'b1; fsync = 1'b1; sclk = 1'b0; sdin = 1'b0;
    wait_cyc(3);
    #1;
    check({dac_code, fast_mode, pwr_down, amps_off, update_strobe} == '0, "R1 in reset",
          {dac_code, fast_mode, pwr_down, amps_off, update_strobe}, 0);
    rst = 1'b0;
    wait_cyc(1);
    #1;
    check({dac_code, fast_mode, pwr_down, amps_off, update_strobe} == '0, "R1 after reset",
          {dac_code, fast_mode, pwr_down, amps_off, update_strobe}, 0);

    // directed corner cases
    run_frame(16'hFFFC, 16, 0);   // R7 all fields set
    run_frame(16'h9003, 16, 0);   // R7 ignored bits 15,12,1,0 only
    run_frame(16'h6AA8, 16, 0);   // R2 ordering pattern
    run_frame(16'h5554, 16, 1);   // R4 sixteen bits, FS before SCLK rise
    run_frame(16'hFFFF, 0, 1);    // R4 empty frame loads nothing
    run_frame(16'hFFFF, 1, 1);    // R4 single bit
    run_frame(16'h7FFF, 9, 1);    // R4 partial, zero fill
    run_frame(16'h0000, 8, 2);    // R6 abort mid frame
    run_frame(16'h0000, 16, 3);   // R5 chip select high
    run_frame(16'h2000, 16, 0);   // R9 power down on
    run_frame(16'h0000, 16, 0);   // R9 power down off

    for (int k = 0; k < 40; k++) begin
      int mode;
      int nb;
      logic [15:0] w;
      mode = int'($urandom % 4);
      w    = 16'($urandom);
      nb   = (mode == 0) ? 16 : int'($urandom % 17);
      run_frame(w, nb, mode);
    end

    check(wide_cnt == 0, "R8 strobe width", wide_cnt, 0);
    check(glitch_cnt == 0, "R8 output change without strobe", glitch_cnt, 0);
    finish_run();
  end
endmodule